// File: doc/BRIEF.md
# Bus-Attached Word Memory with Decoded Rows

This block is a small static storage array that hangs off a shared system bus. A requester places a byte address on the address pins and issues a command on two control lines: `en` enables an access and `rw` picks its direction, 1 for read and 0 for write. The data pins form one bidirectional bus. The requester drives them for a write. The memory drives them only while a read command is held.

Each storage row is exactly one bus word wide, so one access moves one whole word. The byte-offset bits at the bottom of the address do not take part in row selection. Any byte address inside a word therefore reaches the row that holds that word. A misaligned flag shows when those offset bits are non-zero during an enabled access.

Inside the block, a decoder turns the row field of the address into a one-hot select. Each row's write enable is its select line ANDed with the write decode. On the read side, every row is masked by its own select line and all the masked rows are ORed into one word. That word goes through the tri-state driver onto the data pins. Writes take effect on the rising clock edge. Read data follows the array combinationally while the read command is held. The command pins are plain level signals with no handshake, so the block never stalls the bus and has no back-pressure.

Top module: `bus_word_memory`

## Requirements
- R1: After reset every row holds zero, so a read of any row in range returns 0.
- R2: The row index is `addr[ADDR_W-1:OFF]`, where OFF = log2(WORD_W/8) (bits 7:2 with the defaults). At most one row is selected, and an index below ROWS selects exactly that row.
- R3: A write command (`en`=1, `rw`=0) stores the word on the data pins into the selected row at the rising clock edge. All other rows keep their contents.
- R4: While a read command (`en`=1, `rw`=1) is held, the data pins carry the selected row's contents in the same cycle.
- R5: A read command changes no row.
- R6: The block does not drive the data pins when `en`=0 or when the command is a write.
- R7: The low OFF address bits (bits 1:0 with the defaults) are ignored for row selection. Byte addresses 4k to 4k+3 all reach row k.
- R8: `misaligned` is 1 exactly when `en`=1 and the low OFF address bits are non-zero. It is 0 whenever `en`=0.
- R9: An index at or above ROWS selects no row. A write there changes nothing, and a read there returns 0.
- R10: With `en`=0 no row changes, whatever the values of `rw`, `addr` and the data pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears every row |
| addr | input | ADDR_W (8) | Byte address |
| en | input | 1 | Access enable |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| mem_data | inout | WORD_W (32) | Shared bidirectional data bus |
| misaligned | output | 1 | Non-zero byte offset during an enabled access |

## Verification
Storage that is wrong can only be seen through a later read. A corrupted row, a lost write, a stray update during a read or idle cycle, or a write to the wrong row each show up as a mismatching word on the data pins. This happens the first time that row is read, which can be one cycle after the bad edge or many cycles later. The bench therefore reads rows often and keeps a reference copy of every row. A fault in the select or collation logic shows at once, in the same cycle as the read command, either as a wrong word or as a merged word. A driver that is enabled at the wrong time corrupts the bus value that the requester itself drives during idle and write cycles.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_cmd_e;

  function automatic bus_cmd_e decode_cmd(input logic en, input logic rw);
    if (!en)    return BUS_IDLE;
    else if (rw) return BUS_READ;
    else         return BUS_WRITE;
  endfunction

endpackage

// File: rtl/bwm_row_decoder.sv
module bwm_row_decoder #(
  parameter int ROWS  = 16,
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output logic [ROWS-1:0]  sel
);

  for (genvar g = 0; g < ROWS; g++) begin : g_line
    assign sel[g] = (idx == IDX_W'(g));
  end

  // Never more than one line high; an index in range must raise its own line.
  always_comb begin
    assert_onehot_sel_R2: assert ($onehot0(sel));
    if (int'(idx) < ROWS) begin
      assert_sel_hits_R2: assert ($countones(sel) == 1);
    end
  end

endmodule

// File: rtl/bwm_word_array.sv
module bwm_word_array #(
  parameter int ROWS   = 16,
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ROWS-1:0]              sel,
  input  logic                         wr,
  input  logic [WORD_W-1:0]            wdata,
  output logic [ROWS-1:0][WORD_W-1:0]  rows_q
);

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic row_we;
    assign row_we = sel[g] & wr;

    always_ff @(posedge clk) begin
      if (!rst_n)      rows_q[g] <= '0;
      else if (row_we) rows_q[g] <= wdata;
    end

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel[g]) |=> rows_q[g] == $past(wdata));
  end

  // Read and idle cycles leave storage untouched (R5, R10).
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> $stable(rows_q));

endmodule

// File: rtl/bwm_collator.sv
module bwm_collator #(
  parameter int ROWS   = 16,
  parameter int WORD_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ROWS-1:0]             sel,
  input  logic [ROWS-1:0][WORD_W-1:0] rows,
  output logic [WORD_W-1:0]           word
);

  logic [ROWS-1:0][WORD_W-1:0] masked;

  for (genvar g = 0; g < ROWS; g++) begin : g_mask
    assign masked[g] = rows[g] & {WORD_W{sel[g]}};
  end

  always_comb begin
    word = '0;
    for (int r = 0; r < ROWS; r++) word = word | masked[r];
  end

  assert_empty_sel_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (word == '0));

endmodule

// File: rtl/bus_word_memory.sv
module bus_word_memory #(
  parameter int ROWS   = 16,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              rw,
  inout  wire  [WORD_W-1:0] mem_data,
  output logic              misaligned
);
  import bwm_pkg::*;

  localparam int BYTES = WORD_W / 8;
  localparam int OFF   = $clog2(BYTES);
  localparam int IDX_W = ADDR_W - OFF;

  bus_cmd_e                    cmd;
  logic                        is_read, is_write;
  logic [IDX_W-1:0]            row_idx;
  logic [ROWS-1:0]             sel;
  logic [ROWS-1:0][WORD_W-1:0] rows_q;
  logic [WORD_W-1:0]           rd_word;

  assign cmd      = decode_cmd(en, rw);
  assign is_read  = (cmd == BUS_READ);
  assign is_write = (cmd == BUS_WRITE);
  assign row_idx  = addr[ADDR_W-1:OFF];

  assign misaligned = en & (|addr[OFF-1:0]);

  bwm_row_decoder #(.ROWS(ROWS), .IDX_W(IDX_W)) u_dec (
    .idx (row_idx),
    .sel (sel)
  );

  bwm_word_array #(.ROWS(ROWS), .WORD_W(WORD_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .wr     (is_write),
    .wdata  (mem_data),
    .rows_q (rows_q)
  );

  bwm_collator #(.ROWS(ROWS), .WORD_W(WORD_W)) u_coll (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .rows  (rows_q),
    .word  (rd_word)
  );

  assign mem_data = is_read ? rd_word : 'z;

  // The collated word must match the addressed row taken directly.
  assert_read_matches_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && int'(row_idx) < ROWS) |-> (rd_word == rows_q[row_idx]));

endmodule

// File: tb/test_bus_word_memory.sv
`timescale 1ns/1ps
module test_bus_word_memory;
  localparam int ROWS = 16, WORD_W = 32, ADDR_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, en, rw, tb_drv, misaligned;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] tb_val;
  wire  [WORD_W-1:0] bus;

  assign bus = tb_drv ? tb_val : 'z;

  int n_run = 0, n_fail = 0;
  logic [WORD_W-1:0] model [ROWS];

  bus_word_memory #(.ROWS(ROWS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_bus_word_memory (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en(en), .rw(rw),
    .mem_data(bus), .misaligned(misaligned)
  );

  function automatic logic [WORD_W-1:0] expect_word(logic [ADDR_W-1:0] a);
    int idx = int'(a[ADDR_W-1:2]);
    return (idx < ROWS) ? model[idx] : '0;
  endfunction

  task automatic check(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
    int idx = int'(a[ADDR_W-1:2]);
    @(negedge clk);
    en = 1; rw = 0; addr = a; tb_drv = 1; tb_val = d;
    #1;
    check("R8 misaligned on write", 32'(misaligned), 32'(a[1:0] != 0));
    check("R6 bus undisturbed on write", bus, d);
    @(posedge clk);
    if (idx < ROWS) model[idx] = d;   // R3, R7; R9 otherwise
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    en = 1; rw = 1; addr = a; tb_drv = 0;
    #1;
    check(req, bus, expect_word(a));
    check("R8 misaligned on read", 32'(misaligned), 32'(a[1:0] != 0));
    @(posedge clk);                   // R5: no update expected
  endtask

  task automatic do_idle(logic [ADDR_W-1:0] a, logic r);
    @(negedge clk);
    en = 0; rw = r; addr = a; tb_drv = 1; tb_val = '0;
    #1;
    check("R6 bus not driven when idle", bus, '0);
    check("R8 flag low when idle", 32'(misaligned), 32'd0);
    @(posedge clk);                   // R10: no update expected
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd2024);
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    rst_n = 0; en = 0; rw = 0; addr = '0; tb_drv = 0; tb_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: every row clear after reset
    for (int r = 0; r < ROWS; r++) do_read(ADDR_W'(r * 4), "R1 reset value");

    // R3/R7: write through a misaligned address, read back through every byte
    do_write(8'h03, 32'hA5A5_0001);
    for (int b = 0; b < 4; b++) do_read(ADDR_W'(b), "R7 offset ignored");
    // R3: neighbour rows untouched
    do_read(8'h04, "R3 neighbour unchanged");
    // R2/R4: top boundary row
    do_write(8'h3C, 32'hDEAD_BEEF);
    do_read(8'h3E, "R4 last row read");
    // R9: out-of-range rows
    do_write(8'h40, 32'h1234_5678);
    do_read(8'h40, "R9 out of range reads zero");
    do_write(8'hFC, 32'hFFFF_FFFF);
    do_read(8'hFC, "R9 top address reads zero");
    do_read(8'h00, "R9 row 0 intact");
    do_read(8'h3C, "R9 row 15 intact");
    // R10: idle with rw=0 and data driven must not write
    do_write(8'h08, 32'h0BAD_F00D);
    do_idle(8'h08, 1'b0);
    do_idle(8'h09, 1'b1);
    do_read(8'h08, "R10 idle left row");
    // R5: repeated reads do not alter storage
    do_read(8'h08, "R5 read stable");
    do_read(8'h08, "R5 read stable again");

    // Random mix against the reference copy
    for (int i = 0; i < 600; i++) begin
      int unsigned k = $urandom % 10;
      logic [ADDR_W-1:0] a = ADDR_W'($urandom % 96);
      if (k < 4)      do_write(a, $urandom);
      else if (k < 8) do_read(a, "R4 random read");
      else            do_idle(a, 1'($urandom));
    end
    for (int r = 0; r < ROWS; r++) do_read(ADDR_W'(r * 4 + 1), "R3 final sweep");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule